// File: doc/BRIEF.md
# Fixed-to-Float Converter

This block turns a signed two's-complement fixed-point word of parameter width `IN_W` into an IEEE-754 single-precision value. Each input word comes with a valid strobe. One clock later the packed float appears with a matching valid strobe and an inexact flag.

The compile-time parameter `FRAC_MODE` selects how the word is read. With `FRAC_MODE = 0` the word is a plain integer. With `FRAC_MODE = 1` the same bits are a fraction in [-1, 1), worth the integer reading times 2^-(IN_W-1), so the exponent is lowered by IN_W-1.

The datapath has four steps, all in one combinational path ahead of a single output register:
- split the word into a sign and an unsigned magnitude;
- find the leading one;
- shift the magnitude so the leading one sits in the hidden-bit place;
- round to nearest with ties to even, then pack the fields.

Zero and the most negative word are handled explicitly. `IN_W` may range from 2 to 126.

Top module: `fix2flt_conv`

## Requirements
- R1: The output packs the sign into bit 31, an 8-bit exponent with bias 127 into bits 30..23, and the 23 fraction bits into bits 22..0. In integer mode a positive input of 2^k gives sign 0, exponent 127+k and fraction 0.
- R2: A negative input sets bit 31. The other fields are those of its absolute value, so -1 gives 0xBF800000, -5 gives 0xC0A00000 and +5 gives 0x40A00000.
- R3: The most negative input converts without overflow and has magnitude 2^(IN_W-1), fraction 0 and inexact 0. For IN_W=32 that is 0xCF000000 in integer mode and 0xBF800000 in fractional mode. For IN_W=48 in integer mode it is 0xD7000000.
- R4: An all-zero input gives +0.0 (0x00000000) with inexact 0 in both modes.
- R5: A magnitude with at most 24 significant bits converts exactly, with inexact 0. Examples: 0x00FFFFFF gives 0x4B7FFFFF and 0x01000002 gives 0x4B800001.
- R6: A longer magnitude is rounded to nearest with ties to even, and inexact is 1 exactly when a dropped bit was nonzero. Examples: 0x01000001 gives 0x4B800000, 0x01000003 gives 0x4B800002, 0x01000005 gives 0x4B800002 and 0x02000003 gives 0x4C000001, each with inexact 1.
- R7: A rounding carry out of the 24-bit mantissa raises the exponent by one and clears the fraction. Examples: 0x01FFFFFF gives 0x4C000000, 0x7FFFFFFF gives 0x4F000000 and 0x80000001 gives 0xCF000000.
- R8: In fractional mode the exponent is the integer-mode exponent minus (IN_W-1). For IN_W=32, 0x40000000 gives 0x3F000000, 0xC0000000 gives 0xBF000000 and 0x00000001 gives 0x30000000.
- R9: Synchronous active-high reset clears out_valid, out_float and out_inexact. out_valid is in_valid delayed by exactly one clock. The result of each valid input appears together with that strobe, including back-to-back inputs.
- R10: With IN_W=48 in integer mode, 19,246,968,550,852 gives 0x558C0A46.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_word for this cycle |
| in_word | input | IN_W | Two's-complement fixed-point input |
| out_valid | output | 1 | High one clock after a valid input |
| out_float | output | 32 | Single-precision result |
| out_inexact | output | 1 | Result was rounded from nonzero dropped bits |

## Verification
Every fault shows in out_float or out_inexact one clock after the triggering input, because there is only one register stage:
- A wrong leading-one position gives an exponent that is off by the same amount, together with a fraction that is shifted.
- A broken sign/magnitude split corrupts negative inputs, and most visibly the most negative word.
- A wrong guard, sticky or tie decision moves the fraction LSB or flips the inexact flag, only on inputs longer than 24 bits.
- A carry that is lost leaves an exponent one too small with an all-zero fraction.

The directed cases sit on each of these edges. A sweep of pseudo-random words is compared against a shift-and-compare model in the bench, in both modes.

// File: rtl/f2f_pkg.sv
package f2f_pkg;

  localparam int FLT_W  = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int BIAS   = 127;
  localparam int SIG_W  = MAN_W + 1;

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] fr;
  } flt_t;

  // Round-to-nearest, ties-to-even increment decision.
  function automatic logic f2f_round_inc(input logic lsb, input logic guard,
                                         input logic sticky);
    return guard & (sticky | lsb);
  endfunction

  // Biased exponent from leading-one position, rounding carry and mode shift.
  function automatic logic [EXP_W-1:0] f2f_exp_field(input int unsigned pos,
                                                     input logic carry,
                                                     input int unsigned shift);
    int e;
    e = BIAS + int'(pos) + int'(carry) - int'(shift);
    return e[EXP_W-1:0];
  endfunction

endpackage

// File: rtl/f2f_sign_mag.sv
module f2f_sign_mag #(
  parameter int W = 32
) (
  input  logic [W-1:0] word,
  output logic         sgn,
  output logic [W-1:0] mag
);

  // Unsigned magnitude of W bits: the most negative word maps to 2^(W-1).
  function automatic logic [W-1:0] abs_val(input logic [W-1:0] x);
    return x[W-1] ? (~x + W'(1)) : x;
  endfunction

  always_comb begin
    sgn = word[W-1];
    mag = abs_val(word);
  end

  // Only the most negative word may produce a magnitude with its top bit set.
  always_comb begin
    if (mag[W-1]) begin
      AST_MAG_TOP_ONLY_MINNEG: assert (word == {1'b1, {(W-1){1'b0}}}); // R3
    end
  end

endmodule

// File: rtl/f2f_lead_one.sv
module f2f_lead_one #(
  parameter int W  = 32,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  mag,
  output logic [PW-1:0] pos,
  output logic          any
);

  function automatic logic [PW-1:0] top_one(input logic [W-1:0] x);
    logic [PW-1:0] p;
    p = '0;
    for (int i = 0; i < W; i++) begin
      if (x[i]) p = PW'(i);
    end
    return p;
  endfunction

  always_comb begin
    any = |mag;
    pos = top_one(mag);
  end

  // The reported position must hold the highest set bit of the magnitude.
  always_comb begin
    if (any) begin
      AST_LEAD_POS_EXACT: assert ((mag >> pos) == W'(1)); // R1
    end
  end

endmodule

// File: rtl/f2f_norm_round.sv
module f2f_norm_round
  import f2f_pkg::*;
#(
  parameter int W         = 32,
  parameter bit FRAC_MODE = 1'b0,
  parameter int PW        = (W > 1) ? $clog2(W) : 1
) (
  input  logic          sgn,
  input  logic [W-1:0]  mag,
  input  logic [PW-1:0] pos,
  input  logic          any,
  output flt_t          res,
  output logic          inexact
);

  localparam int NW        = W + SIG_W;
  localparam int EXP_SHIFT = FRAC_MODE ? (W - 1) : 0;

  logic [NW-1:0]    normx;
  logic [PW-1:0]    shamt;
  logic [MAN_W-1:0] frac_raw;
  logic             guard_bit;
  logic             sticky_bit;
  logic             round_inc;
  logic [SIG_W-1:0] mant_sum;
  logic             mant_carry;
  logic             hidden_bit;

  always_comb begin
    shamt      = PW'(W - 1) - pos;
    normx      = {mag, {SIG_W{1'b0}}} << shamt;
    hidden_bit = normx[NW-1];
    frac_raw   = normx[NW-2 -: MAN_W];
    guard_bit  = normx[NW-2-MAN_W];
    sticky_bit = |normx[NW-3-MAN_W:0];
    round_inc  = f2f_round_inc(frac_raw[0], guard_bit, sticky_bit);
    mant_sum   = {1'b0, frac_raw} + SIG_W'(round_inc);
    mant_carry = mant_sum[MAN_W];
  end

  always_comb begin
    res.sgn = sgn & any;
    if (any) begin
      res.ex = f2f_exp_field(int'(pos), mant_carry, EXP_SHIFT);
      res.fr = mant_sum[MAN_W-1:0];
    end else begin
      res.ex = '0;
      res.fr = '0;
    end
    inexact = any & (guard_bit | sticky_bit);
  end

  always_comb begin
    if (any) begin
      AST_NORM_HIDDEN_SET: assert (hidden_bit); // R1
    end
    if (mant_carry) begin
      AST_CARRY_NEEDS_ROUND: assert (round_inc && inexact); // R7
    end
    if (round_inc) begin
      AST_ROUND_ONLY_INEXACT: assert (inexact); // R6
    end
  end

endmodule

// File: rtl/fix2flt_conv.sv
module fix2flt_conv
  import f2f_pkg::*;
#(
  parameter int IN_W      = 32,
  parameter bit FRAC_MODE = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_word,
  output logic            out_valid,
  output logic [31:0]     out_float,
  output logic            out_inexact
);

  localparam int PW = (IN_W > 1) ? $clog2(IN_W) : 1;

  logic            sgn_w;
  logic [IN_W-1:0] mag_w;
  logic [PW-1:0]   pos_w;
  logic            any_w;
  flt_t            res_w;
  logic            inexact_w;

  f2f_sign_mag #(.W(IN_W)) u_sign_mag (
    .word (in_word),
    .sgn  (sgn_w),
    .mag  (mag_w)
  );

  f2f_lead_one #(.W(IN_W), .PW(PW)) u_lead_one (
    .mag (mag_w),
    .pos (pos_w),
    .any (any_w)
  );

  f2f_norm_round #(.W(IN_W), .FRAC_MODE(FRAC_MODE), .PW(PW)) u_norm_round (
    .sgn     (sgn_w),
    .mag     (mag_w),
    .pos     (pos_w),
    .any     (any_w),
    .res     (res_w),
    .inexact (inexact_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_float   <= '0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_float   <= res_w;
        out_inexact <= inexact_w;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R9
  AST_ZERO_IS_POS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word == '0) |=> (out_float == 32'h0 && !out_inexact)); // R4
  AST_SIGN_CARRIED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word != '0) |=> out_float[31] == $past(in_word[IN_W-1])); // R2
  AST_SHORT_EXACT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && any_w && int'(pos_w) < SIG_W) |=> !out_inexact); // R5

endmodule

// File: tb/fix2flt_conv_tb_top.sv
module fix2flt_conv_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] w32 = '0;
  logic [47:0] w48 = '0;

  logic        ov_i, ov_f, ov_w;
  logic [31:0] of_i, of_f, of_w;
  logic        ox_i, ox_f, ox_w;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  fix2flt_conv #(.IN_W(32), .FRAC_MODE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(w32),
    .out_valid(ov_i), .out_float(of_i), .out_inexact(ox_i));

  fix2flt_conv #(.IN_W(32), .FRAC_MODE(1'b1)) dut_f (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(w32),
    .out_valid(ov_f), .out_float(of_f), .out_inexact(ox_f));

  fix2flt_conv #(.IN_W(48), .FRAC_MODE(1'b0)) dut_w (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(w48),
    .out_valid(ov_w), .out_float(of_w), .out_inexact(ox_w));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one valid word on all DUTs; outputs are sampled 1 ns after the capturing edge.
  task automatic apply(input logic [31:0] v32, input logic [47:0] v48);
    @(negedge clk);
    in_valid = 1'b1;
    w32 = v32;
    w48 = v48;
    @(posedge clk);
    #1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Bench model: shift right until 24 bits remain, round on the remainder.
  task automatic ref_conv(input longint signed v, input int w, input bit frac,
                          output logic [31:0] f, output bit inx);
    longint unsigned mag, kept, rem, half;
    int sh, e;
    bit neg, up;
    if (v == 0) begin
      f = 32'h0; inx = 1'b0;
      return;
    end
    neg = (v < 0);
    mag = neg ? longint'(-v) : longint'(v);
    sh = 0;
    while ((mag >> sh) >= 64'd16777216) sh++;
    kept = mag >> sh;
    rem  = mag - (kept << sh);
    half = (sh > 0) ? (64'd1 << (sh - 1)) : 64'd0;
    up   = (sh > 0) && ((rem > half) || (rem == half && kept[0]));
    inx  = (rem != 0);
    kept = kept + longint'(up);
    if (kept == 64'd16777216) begin kept = kept >> 1; sh++; end
    while (kept < 64'd8388608) begin kept = kept << 1; sh--; end
    e = 150 + sh - (frac ? (w - 1) : 0);
    f = {neg, e[7:0], kept[22:0]};
  endtask

  task automatic t_reset();
    chk("R9 reset valid", {29'b0, ov_i, ov_f, ov_w}, 32'h0);
    chk("R9 reset float", of_i | of_f, 32'h0);
    chk("R9 reset inexact", {30'b0, ox_i, ox_w}, 32'h0);
  endtask

  task automatic t_powers();
    int ks[5] = '{0, 1, 7, 23, 30};
    foreach (ks[j]) begin
      apply(32'h1 << ks[j], 48'h1 << ks[j]);
      chk("R1 int power", of_i, {1'b0, 8'(127 + ks[j]), 23'b0});
      chk("R1 wide power", of_w, {1'b0, 8'(127 + ks[j]), 23'b0});
      chk("R8 frac power", of_f, {1'b0, 8'(96 + ks[j]), 23'b0});
    end
  endtask

  task automatic t_sign();
    apply(32'hFFFFFFFF, 48'hFFFFFFFFFFFF);
    chk("R2 minus one", of_i, 32'hBF800000);
    chk("R2 minus one wide", of_w, 32'hBF800000);
    apply(32'hFFFFFFFB, 48'hFFFFFFFFFFFB);
    chk("R2 minus five", of_i, 32'hC0A00000);
    apply(32'h5, 48'h5);
    chk("R2 plus five", of_i, 32'h40A00000);
  endtask

  task automatic t_minneg();
    apply(32'h80000000, 48'h800000000000);
    chk("R3 int minneg", of_i, 32'hCF000000);
    chk("R3 int minneg inexact", {31'b0, ox_i}, 32'h0);
    chk("R3 frac minneg", of_f, 32'hBF800000);
    chk("R3 wide minneg", of_w, 32'hD7000000);
  endtask

  task automatic t_zero();
    apply(32'h0, 48'h0);
    chk("R4 zero int", of_i, 32'h0);
    chk("R4 zero frac", of_f, 32'h0);
    chk("R4 zero wide", of_w, 32'h0);
    chk("R4 zero inexact", {30'b0, ox_i, ox_f}, 32'h0);
  endtask

  task automatic t_exact();
    apply(32'h00FFFFFF, 48'h0);
    chk("R5 24 ones", of_i, 32'h4B7FFFFF);
    chk("R5 24 ones inexact", {31'b0, ox_i}, 32'h0);
    apply(32'h01000002, 48'h0);
    chk("R5 even 25 bit", of_i, 32'h4B800001);
    chk("R5 even 25 bit inexact", {31'b0, ox_i}, 32'h0);
  endtask

  task automatic t_round();
    apply(32'h01000001, 48'h0);
    chk("R6 tie down", of_i, 32'h4B800000);
    chk("R6 tie down inexact", {31'b0, ox_i}, 32'h1);
    apply(32'h01000003, 48'h0);
    chk("R6 tie up", of_i, 32'h4B800002);
    apply(32'h01000005, 48'h0);
    chk("R6 tie even", of_i, 32'h4B800002);
    chk("R6 tie even inexact", {31'b0, ox_i}, 32'h1);
    apply(32'h02000003, 48'h0);
    chk("R6 sticky up", of_i, 32'h4C000001);
  endtask

  task automatic t_carry();
    apply(32'h01FFFFFF, 48'h0);
    chk("R7 carry 25", of_i, 32'h4C000000);
    chk("R7 carry inexact", {31'b0, ox_i}, 32'h1);
    apply(32'h7FFFFFFF, 48'h0);
    chk("R7 carry max", of_i, 32'h4F000000);
    apply(32'h80000001, 48'h0);
    chk("R7 carry neg", of_i, 32'hCF000000);
  endtask

  task automatic t_frac();
    apply(32'h40000000, 48'h0);
    chk("R8 half", of_f, 32'h3F000000);
    apply(32'hC0000000, 48'h0);
    chk("R8 minus half", of_f, 32'hBF000000);
    apply(32'h00000001, 48'h0);
    chk("R8 lsb", of_f, 32'h30000000);
  endtask

  task automatic t_wide();
    apply(32'h0, 48'd19246968550852);
    chk("R10 wide value", of_w, 32'h558C0A46);
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1'b1; w32 = 32'h00000003; w48 = '0;
    @(posedge clk); #1;
    chk("R9 first valid", {31'b0, ov_i}, 32'h1);
    chk("R9 first value", of_i, 32'h40400000);
    @(negedge clk);
    w32 = 32'hFFFFFFFE;
    @(posedge clk); #1;
    chk("R9 second valid", {31'b0, ov_i}, 32'h1);
    chk("R9 second value", of_i, 32'hC0000000);
    @(negedge clk);
    in_valid = 1'b0; w32 = 32'h12345678;
    @(posedge clk); #1;
    chk("R9 idle valid", {31'b0, ov_i}, 32'h0);
    chk("R9 idle hold", of_i, 32'hC0000000);
  endtask

  task automatic t_sweep();
    logic [31:0] lfsr = 32'hACE12471;
    logic [31:0] ef;
    bit ex;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr >> (n % 9), 48'h0);
      ref_conv(longint'($signed(lfsr >> (n % 9))), 32, 1'b0, ef, ex);
      chk("R6 sweep int", of_i, ef);
      chk("R6 sweep int inexact", {31'b0, ox_i}, {31'b0, ex});
      ref_conv(longint'($signed(lfsr >> (n % 9))), 32, 1'b1, ef, ex);
      chk("R8 sweep frac", of_f, ef);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R9 idle after reset", {29'b0, ov_i, ov_f, ov_w}, 32'h0);
    t_powers();
    t_sign();
    t_minneg();
    t_zero();
    t_exact();
    t_round();
    t_carry();
    t_frac();
    t_wide();
    t_latency();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule